// File: doc/BRIEF.md
# Byte-Wide Handshake Bus Slave

This block sits on the FPGA side of an 8-bit parallel link to an external microcontroller. The microcontroller is the master. It opens a transaction with a short pulse on a start line and sends a six-byte request: a command byte, a register address byte and a 32-bit data word sent lowest byte first. It then reads back an eight-byte reply: a 32-bit data word followed by a 32-bit status word, each sent lowest byte first. Every byte moves under a four-phase handshake. The master owns one strobe line and the slave owns the other, and a read/write line from the master sets which side drives the bus.

All master control lines are asynchronous. Each one passes through a two-flop synchroniser before the controller uses it. A valid request goes out on an internal register port as a valid/ready request channel. The slave holds `req_valid` and keeps the whole payload stable until the register side asserts `req_ready`. The register side then returns exactly one `rsp_valid` pulse, one cycle or later after the handshake, and the slave always accepts it. The slave keeps `txn_active_o` high for the whole exchange. The master waits for this line to fall before it ends the transaction. The data bus is split into an input, an output and an output enable, and an outer pad drives the bus from these.

Top module: `byte_bus_slave`

## Requirements
- R1: While the system reset `rst_n` is low, or after the master reset line `mst_rst_n_i` has been low for at least 3 clocks, `txn_active_o`, `slv_strobe_o`, `bus_oe` and `reg_req_valid` are all low. A partly received packet is discarded and issues no register request.
- R2: `txn_active_o` rises within 6 clocks of a rising edge on `mst_start_i` when start is held high for at least 2 clocks. It stays high through all 14 bytes and falls within 6 clocks after the master strobe falls for the last reply byte.
- R3: For a request byte (`mst_rd_i` = 0), `slv_strobe_o` rises no sooner than 2 clocks after `mst_strobe_i` rises, and the byte on `bus_in` is captured at that point. It stays high while the master strobe is high and falls after the master strobe falls.
- R4: For a reply byte (`mst_rd_i` = 1), the slave drives the byte with `bus_oe` high and then raises `slv_strobe_o`. It drops the strobe after `mst_strobe_i` rises, and `bus_out` stays constant until the master strobe falls.
- R5: Request byte 0 is the command, byte 1 is the register address, and bytes 2 to 5 are the data word, lowest byte first.
- R6: Reply bytes 0 to 3 are the data word and bytes 4 to 7 are the status word, each lowest byte first.
- R7: Command 0x01 (write) with a valid address issues exactly one request with `reg_req_write` = 1 and the received address and data. `reg_req_valid` and the payload hold steady until `reg_req_ready`. The reply carries `reg_rsp_rdata` and status 0.
- R8: Command 0x02 (read) with a valid address issues one request with `reg_req_write` = 0. The reply data word is the `reg_rsp_rdata` returned, and no reply byte is offered before `reg_rsp_valid`.
- R9: An unknown command gives status 1. A known command with an address of `NUM_REGS` or more gives status 2. The command check takes priority. In both cases the reply data word is 0 and no register request is made.
- R10: `bus_oe` is high only during reply bytes while `mst_rd_i` is 1, and never while request bytes are received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| mst_start_i | input | 1 | Master transaction start pulse (asynchronous) |
| mst_strobe_i | input | 1 | Master handshake strobe (asynchronous) |
| mst_rd_i | input | 1 | Master direction: 1 = slave drives bus, 0 = master drives |
| mst_rst_n_i | input | 1 | Master reset line, active low (asynchronous) |
| bus_in | input | 8 | Byte read from the bus pads |
| bus_out | output | 8 | Byte presented to the bus pads |
| bus_oe | output | 1 | Pad output enable |
| slv_strobe_o | output | 1 | Slave handshake strobe |
| txn_active_o | output | 1 | High for the duration of a transaction |
| reg_req_valid | output | 1 | Register request valid |
| reg_req_ready | input | 1 | Register request accepted |
| reg_req_write | output | 1 | 1 = write access, 0 = read access |
| reg_req_addr | output | 8 | Register address |
| reg_req_wdata | output | 32 | Write data |
| reg_rsp_valid | input | 1 | Register response pulse |
| reg_rsp_rdata | input | 32 | Register contents after the access |

## Verification
A controller stuck in a handshake state shows at the pins as a slave strobe that never rises or never falls. The master then stalls within a few tens of clocks on the byte in question. A bad byte counter or a wrong reply index does not stall anything. It shows only as a wrong data or status word when the transaction completes, or as `txn_active_o` falling early or late against the 14th byte. A decode fault shows on the register port in the same transaction, as a request that should not appear or a missing one.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;

  localparam int CMD_WRITE = 8'h01;
  localparam int CMD_READ  = 8'h02;

  localparam int STAT_OK       = 0;
  localparam int STAT_BAD_CMD  = 1;
  localparam int STAT_BAD_ADDR = 2;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RX_HI,
    S_RX_LO,
    S_DECODE,
    S_REQ,
    S_RSP,
    S_TX_PRE,
    S_TX_HI,
    S_TX_LO
  } bbs_state_e;
endpackage

// File: rtl/bbs_sync.sv
module bbs_sync #(
  parameter int           W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/bbs_req_asm.sv
module bbs_req_asm #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 6,
  parameter int IDX_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  logic [BYTE_W-1:0]        din,
  output logic [NBYTES*BYTE_W-1:0] pkt
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pkt[g*BYTE_W +: BYTE_W] <= '0;
      else if (we && idx == IDX_W'(g))
        pkt[g*BYTE_W +: BYTE_W] <= din;
    end
  end
endmodule

// File: rtl/bbs_reply_mux.sv
module bbs_reply_mux #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 8,
  parameter int IDX_W  = 3
) (
  input  logic [NBYTES*BYTE_W-1:0] word,
  input  logic [IDX_W-1:0]         idx,
  output logic [BYTE_W-1:0]        byte_o
);
  always_comb begin
    byte_o = '0;
    for (int i = 0; i < NBYTES; i++)
      if (idx == IDX_W'(i)) byte_o = word[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/byte_bus_slave.sv
module byte_bus_slave
  import bbs_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int BW       = BYTE_W,
  parameter int WB       = WORD_BYTES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mst_start_i,
  input  logic            mst_strobe_i,
  input  logic            mst_rd_i,
  input  logic            mst_rst_n_i,
  input  logic [BW-1:0]   bus_in,
  output logic [BW-1:0]   bus_out,
  output logic            bus_oe,
  output logic            slv_strobe_o,
  output logic            txn_active_o,
  output logic            reg_req_valid,
  input  logic            reg_req_ready,
  output logic            reg_req_write,
  output logic [BW-1:0]   reg_req_addr,
  output logic [BW*WB-1:0] reg_req_wdata,
  input  logic            reg_rsp_valid,
  input  logic [BW*WB-1:0] reg_rsp_rdata
);
  localparam int WORD_W    = BW * WB;
  localparam int REQ_BYTES = 2 + WB;
  localparam int RSP_BYTES = 2 * WB;
  localparam int MAX_BYTES = (RSP_BYTES > REQ_BYTES) ? RSP_BYTES : REQ_BYTES;
  localparam int CNT_W     = $clog2(MAX_BYTES);
  localparam logic [CNT_W-1:0] REQ_LAST = CNT_W'(REQ_BYTES - 1);
  localparam logic [CNT_W-1:0] RSP_LAST = CNT_W'(RSP_BYTES - 1);
  localparam logic [BW:0]      NREG_L   = (BW+1)'(NUM_REGS);

  // synchronised master controls: {reset_n, rd, strobe, start}
  logic [3:0] ctl_s;
  logic start_s, hs1_s, rd_s, mrst_s;

  bbs_sync #(.W(4), .RST_VAL(4'b0000)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({mst_rst_n_i, mst_rd_i, mst_strobe_i, mst_start_i}),
    .q   (ctl_s)
  );
  assign start_s = ctl_s[0];
  assign hs1_s   = ctl_s[1];
  assign rd_s    = ctl_s[2];
  assign mrst_s  = ctl_s[3];

  bbs_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic               strobe_q, busy_q, req_v_q, start_q;
  logic [WORD_W-1:0]  status_q, rdata_q;

  // request packet assembly
  logic [REQ_BYTES*BW-1:0] pkt;
  logic                    rx_we;
  assign rx_we = (state == S_RX_HI) && hs1_s && !rd_s;

  bbs_req_asm #(.BYTE_W(BW), .NBYTES(REQ_BYTES), .IDX_W(CNT_W)) u_asm (
    .clk (clk),
    .rst_n (rst_n),
    .we  (rx_we),
    .idx (cnt),
    .din (bus_in),
    .pkt (pkt)
  );

  logic [BW-1:0]     cmd_b, addr_b;
  logic [WORD_W-1:0] wdata_w;
  logic              cmd_wr, cmd_rd, cmd_known, addr_ok;
  assign cmd_b     = pkt[BW-1:0];
  assign addr_b    = pkt[2*BW-1:BW];
  assign wdata_w   = pkt[REQ_BYTES*BW-1:2*BW];
  assign cmd_wr    = (cmd_b == BW'(CMD_WRITE));
  assign cmd_rd    = (cmd_b == BW'(CMD_READ));
  assign cmd_known = cmd_wr || cmd_rd;
  assign addr_ok   = ({1'b0, addr_b} < NREG_L);

  // reply disassembly
  logic [BW-1:0] tx_byte;
  bbs_reply_mux #(.BYTE_W(BW), .NBYTES(RSP_BYTES), .IDX_W(CNT_W)) u_mux (
    .word   ({status_q, rdata_q}),
    .idx    (cnt),
    .byte_o (tx_byte)
  );

  logic in_tx;
  assign in_tx = (state == S_TX_PRE) || (state == S_TX_HI) || (state == S_TX_LO);

  assign bus_oe        = in_tx && rd_s;
  assign bus_out       = bus_oe ? tx_byte : '0;
  assign slv_strobe_o  = strobe_q;
  assign txn_active_o  = busy_q;
  assign reg_req_valid = req_v_q;
  assign reg_req_write = cmd_wr;
  assign reg_req_addr  = addr_b;
  assign reg_req_wdata = wdata_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      strobe_q <= 1'b0;
      busy_q   <= 1'b0;
      req_v_q  <= 1'b0;
      start_q  <= 1'b0;
      status_q <= '0;
      rdata_q  <= '0;
    end else begin
      start_q <= start_s;
      if (!mrst_s) begin
        state    <= S_IDLE;
        cnt      <= '0;
        strobe_q <= 1'b0;
        busy_q   <= 1'b0;
        req_v_q  <= 1'b0;
      end else begin
        case (state)
          S_IDLE:
            if (start_s && !start_q) begin
              busy_q <= 1'b1;
              cnt    <= '0;
              state  <= S_RX_HI;
            end
          S_RX_HI:
            if (hs1_s && !rd_s) begin
              strobe_q <= 1'b1;
              state    <= S_RX_LO;
            end
          S_RX_LO:
            if (!hs1_s) begin
              strobe_q <= 1'b0;
              if (cnt == REQ_LAST) begin
                cnt   <= '0;
                state <= S_DECODE;
              end else begin
                cnt   <= cnt + 1'b1;
                state <= S_RX_HI;
              end
            end
          S_DECODE:
            if (!cmd_known) begin
              status_q <= WORD_W'(STAT_BAD_CMD);
              rdata_q  <= '0;
              state    <= S_TX_PRE;
            end else if (!addr_ok) begin
              status_q <= WORD_W'(STAT_BAD_ADDR);
              rdata_q  <= '0;
              state    <= S_TX_PRE;
            end else begin
              status_q <= WORD_W'(STAT_OK);
              req_v_q  <= 1'b1;
              state    <= S_REQ;
            end
          S_REQ:
            if (reg_req_ready) begin
              req_v_q <= 1'b0;
              state   <= S_RSP;
            end
          S_RSP:
            if (reg_rsp_valid) begin
              rdata_q <= reg_rsp_rdata;
              state   <= S_TX_PRE;
            end
          S_TX_PRE:
            if (rd_s && !hs1_s) begin
              strobe_q <= 1'b1;
              state    <= S_TX_HI;
            end
          S_TX_HI:
            if (hs1_s) begin
              strobe_q <= 1'b0;
              state    <= S_TX_LO;
            end
          S_TX_LO:
            if (!hs1_s) begin
              if (cnt == RSP_LAST) begin
                busy_q <= 1'b0;
                cnt    <= '0;
                state  <= S_IDLE;
              end else begin
                cnt   <= cnt + 1'b1;
                state <= S_TX_PRE;
              end
            end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // the slave strobe rises only when the master side is ready for it:
  // strobe high with rd low (request byte) or strobe low with rd high (reply)
  assert_strobe_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slv_strobe_o) |-> ($past(hs1_s) != $past(rd_s)));

  assert_byte_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && slv_strobe_o && $past(bus_oe && slv_strobe_o)) |-> $stable(bus_out));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || !mrst_s)
    (reg_req_valid && !reg_req_ready) |=>
      (reg_req_valid && $stable(reg_req_addr) && $stable(reg_req_wdata) && $stable(reg_req_write)));

  assert_req_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid |-> (status_q == WORD_W'(STAT_OK)) && busy_q);

  assert_oe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (txn_active_o && !reg_req_valid));

  assert_busy_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txn_active_o) |-> (!slv_strobe_o && !reg_req_valid));
endmodule

// File: tb/test_byte_bus_slave.sv
module test_byte_bus_slave;
  import bbs_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NREGS      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mst_start = 1'b0, mst_strobe = 1'b0, mst_rd = 1'b0, mst_rst_n = 1'b1;
  logic [7:0]  bus_in = '0;
  logic [7:0]  bus_out;
  logic        bus_oe, slv_strobe, txn_active;
  logic        reg_req_valid, reg_req_ready, reg_req_write;
  logic [7:0]  reg_req_addr;
  logic [31:0] reg_req_wdata;
  logic        reg_rsp_valid;
  logic [31:0] reg_rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_bus_slave #(.NUM_REGS(NREGS)) i_byte_bus_slave (
    .clk (clk), .rst_n (rst_n),
    .mst_start_i (mst_start), .mst_strobe_i (mst_strobe),
    .mst_rd_i (mst_rd), .mst_rst_n_i (mst_rst_n),
    .bus_in (bus_in), .bus_out (bus_out), .bus_oe (bus_oe),
    .slv_strobe_o (slv_strobe), .txn_active_o (txn_active),
    .reg_req_valid (reg_req_valid), .reg_req_ready (reg_req_ready),
    .reg_req_write (reg_req_write), .reg_req_addr (reg_req_addr),
    .reg_req_wdata (reg_req_wdata), .reg_rsp_valid (reg_rsp_valid),
    .reg_rsp_rdata (reg_rsp_rdata)
  );

  int n_chk = 0, n_fail = 0;
  logic [63:0] exp_q[$];
  logic [63:0] act_q[$];
  logic [31:0] mem    [NREGS];
  logic [31:0] shadow [NREGS];
  int          lat = 0, req_count = 0, wr_count = 0;
  logic [7:0]  last_addr = '0;
  logic [31:0] last_wdata = '0;
  logic        last_write = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // register side model behind the port
  initial begin
    reg_req_ready = 1'b0;
    reg_rsp_valid = 1'b0;
    reg_rsp_rdata = '0;
    for (int i = 0; i < NREGS; i++) mem[i] = 32'hC0DE0000 + i;
    forever begin
      @(negedge clk);
      if (reg_req_valid) begin
        repeat (lat) @(negedge clk);
        reg_req_ready = 1'b1;
        last_addr  = reg_req_addr;
        last_wdata = reg_req_wdata;
        last_write = reg_req_write;
        req_count++;
        @(negedge clk);
        reg_req_ready = 1'b0;
        if (last_write) begin
          mem[int'(last_addr) % NREGS] = last_wdata;
          wr_count++;
        end
        reg_rsp_rdata = mem[int'(last_addr) % NREGS];
        reg_rsp_valid = 1'b1;
        @(negedge clk);
        reg_rsp_valid = 1'b0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [63:0] a, e;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        chk(a == e, "R6", "reply {status,data}", a, e);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    report();
  end

  task automatic send_byte(input logic [7:0] b);
    int n;
    chk(!slv_strobe, "R3", "slave strobe low before byte", 64'(slv_strobe), 0);
    bus_in = b;
    mst_rd = 1'b0;
    mst_strobe = 1'b1;
    n = 0;
    while (!slv_strobe && n < 60) begin @(negedge clk); n++; end
    chk(slv_strobe && n >= 2, "R3", "slave strobe answers after sync", 64'(n), 2);
    chk(!bus_oe, "R10", "no drive during request byte", 64'(bus_oe), 0);
    repeat (2) @(negedge clk);
    chk(slv_strobe, "R3", "slave strobe held", 64'(slv_strobe), 1);
    mst_strobe = 1'b0;
    n = 0;
    while (slv_strobe && n < 60) begin @(negedge clk); n++; end
    chk(!slv_strobe, "R3", "slave strobe released", 64'(slv_strobe), 0);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    int n;
    mst_rd = 1'b1;
    n = 0;
    while (!slv_strobe && n < 60) begin @(negedge clk); n++; end
    chk(slv_strobe && bus_oe, "R4", "byte offered with drive", {62'b0, slv_strobe, bus_oe}, 3);
    b = bus_out;
    @(negedge clk);
    chk(bus_out == b, "R4", "byte stable before master strobe", 64'(bus_out), 64'(b));
    mst_strobe = 1'b1;
    n = 0;
    while (slv_strobe && n < 60) begin @(negedge clk); n++; end
    chk(!slv_strobe && bus_out == b, "R4", "strobe dropped, byte held", 64'(bus_out), 64'(b));
    chk(txn_active, "R2", "active during reply", 64'(txn_active), 1);
    mst_strobe = 1'b0;
  endtask

  task automatic start_pulse();
    int n;
    @(negedge clk);
    mst_start = 1'b1;
    repeat (3) @(negedge clk);
    mst_start = 1'b0;
    n = 0;
    while (!txn_active && n < 6) begin @(negedge clk); n++; end
    chk(txn_active, "R2", "active after start", 64'(txn_active), 1);
  endtask

  // driver: pushes the expected reply, then plays the master
  task automatic txn(input logic [7:0] cmd, input logic [7:0] addr,
                     input logic [31:0] wd, input logic [63:0] exp);
    logic [7:0]  rb;
    logic [63:0] got;
    int n;
    exp_q.push_back(exp);
    start_pulse();
    send_byte(cmd);
    send_byte(addr);
    for (int k = 0; k < 4; k++) send_byte(wd[8*k +: 8]);
    got = '0;
    for (int k = 0; k < 8; k++) begin
      recv_byte(rb);
      got[8*k +: 8] = rb;
    end
    n = 0;
    while (txn_active && n < 6) begin @(negedge clk); n++; end
    chk(!txn_active, "R2", "active falls after last byte", 64'(txn_active), 0);
    act_q.push_back(got);
  endtask

  initial begin
    int rc, wc;
    for (int i = 0; i < NREGS; i++) shadow[i] = 32'hC0DE0000 + i;
    repeat (3) @(negedge clk);
    chk(!txn_active && !slv_strobe && !bus_oe && !reg_req_valid, "R1", "outputs in reset",
        {60'b0, txn_active, slv_strobe, bus_oe, reg_req_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!txn_active && !slv_strobe && !bus_oe && !reg_req_valid, "R1", "idle after reset",
        {60'b0, txn_active, slv_strobe, bus_oe, reg_req_valid}, 0);

    // write, no latency
    lat = 0; rc = req_count; wc = wr_count;
    txn(8'h01, 8'd3, 32'hDEADBEEF, {32'h0, 32'hDEADBEEF});
    shadow[3] = 32'hDEADBEEF;
    chk(req_count == rc + 1 && wr_count == wc + 1, "R7", "one write request",
        64'(req_count - rc), 1);
    chk(last_write && last_addr == 8'd3, "R5", "command and address bytes",
        {55'b0, last_write, last_addr}, {55'b0, 1'b1, 8'd3});
    chk(last_wdata == 32'hDEADBEEF, "R5", "data word byte order", 64'(last_wdata), 64'(32'hDEADBEEF));

    // reads with latency
    lat = 2; rc = req_count;
    txn(8'h02, 8'd3, 32'h0, {32'h0, shadow[3]});
    chk(req_count == rc + 1 && !last_write, "R8", "one read request",
        64'(req_count - rc), 1);
    txn(8'h02, 8'd0, 32'hFFFFFFFF, {32'h0, shadow[0]});

    // top address, slow register side
    lat = 3;
    txn(8'h01, 8'(NREGS - 1), 32'h12345678, {32'h0, 32'h12345678});
    shadow[NREGS-1] = 32'h12345678;
    txn(8'h02, 8'(NREGS - 1), 32'h0, {32'h0, shadow[NREGS-1]});

    // error codes, no requests
    lat = 0; rc = req_count;
    txn(8'h7F, 8'd2, 32'hFFFFFFFF, {32'd1, 32'h0});
    txn(8'h00, 8'd40, 32'h0, {32'd1, 32'h0});
    txn(8'h01, 8'(NREGS), 32'h55555555, {32'd2, 32'h0});
    txn(8'h02, 8'hFF, 32'h0, {32'd2, 32'h0});
    chk(req_count == rc, "R9", "no request on error", 64'(req_count - rc), 0);
    txn(8'h02, 8'd2, 32'h0, {32'h0, shadow[2]});

    // master reset mid-packet
    rc = req_count;
    start_pulse();
    send_byte(8'h01);
    send_byte(8'd5);
    send_byte(8'hAA);
    mst_rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(!txn_active && !slv_strobe && !bus_oe && !reg_req_valid, "R1", "idle under master reset",
        {60'b0, txn_active, slv_strobe, bus_oe, reg_req_valid}, 0);
    mst_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_count == rc, "R1", "partial packet dropped", 64'(req_count - rc), 0);
    txn(8'h01, 8'd7, 32'hA5A50F0F, {32'h0, 32'hA5A50F0F});
    shadow[7] = 32'hA5A50F0F;
    txn(8'h02, 8'd5, 32'h0, {32'h0, shadow[5]});
    txn(8'h02, 8'd7, 32'h0, {32'h0, shadow[7]});

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0 && act_q.size() == 0, "R6", "scoreboard drained",
        64'(exp_q.size() + act_q.size()), 0);
    report();
  end
endmodule